// File: doc/BRIEF.md
# Rate Sensor Power-On Initialization Sequencer

This block takes a digital rate sensor from power-up to normal operation. After a start pulse it waits out the sensor's power-up time. It then issues four sensor-data requests and one fault-register read through a separate frame codec, with settle delays between some of the requests. It checks each reply against the pattern the sensor must return at that step. The block does no serial shifting of its own. It hands a 32-bit command word to the codec and waits for the codec's 32-bit reply or its transport error.

At the end of the sequence the block raises `done_o`. If the sequence failed, it also raises `err_o` with a code naming the failing step. A power-on reply that does not match the expected value only raises `warn_o`, and the sequence goes on. The captured fault field is available on `fault_o`. All results hold until the next start. Delays are counted in milliseconds by an internal prescaler of `CLKS_PER_MS` clock cycles, which restarts each time a delay begins. This makes every delay exactly `ms * CLKS_PER_MS` cycles long, and a shortened configuration can be used in simulation.

Top module: `gyro_init_seq`

## Requirements
- R1: After reset, `done_o`, `err_o`, `warn_o` and `xfer_req_o` are low, and `err_code_o` and `fault_o` are zero.
- R2: A start accepted at a clock edge produces the first request exactly POWERUP_MS*CLKS_PER_MS+1 cycles after that edge. Its command word is 0x20000003: opcode 0x20 in bits 31:24, with the check bit (bit 1) and the parity bit (bit 0) set.
- R3: If the full reply to the first request is not 0x00000001, `warn_o` rises and the sequence continues. If it equals 0x00000001, `warn_o` stays low.
- R4: The second and third requests carry the plain command 0x20000000. Each one starts SETTLE_MS*CLKS_PER_MS+1 cycles after the edge that accepted the previous reply.
- R5: The third reply passes only if bits 7:1 are all ones and bits 27:26 equal 2'b10; bit 0 and all other bits are ignored. A failing reply ends the sequence with code 2.
- R6: The fourth request (0x20000000) starts in the cycle right after the third reply is accepted, with no delay. Its reply gets the same check as the third, and a failure ends the sequence with code 3.
- R7: The fifth request reads the fault register with command 0x80140000: read opcode 0x80 in bits 31:24, register address 0x0A in bits 24:17, and bit 0 set only when the rest of the word has an even number of ones. Reply bits 16:5 are captured on `fault_o` (bit 0 of `fault_o` = reply bit 5). Any set bit there ends the sequence with code 4. Reply bits outside 16:5 are ignored.
- R8: A reply flagged with `xfer_err_i` ends the sequence at once with code 1. No further request is made, and the pattern checks and warning for that reply are skipped.
- R9: `done_o` rises when the sequence ends, whether it passed or failed, and `err_o` rises with it only on failure; code 0 means success. `done_o`, `err_o`, `err_code_o`, `warn_o` and `fault_o` hold until the next start. A start while done restarts the sequence and clears them all.
- R10: A start pulse while a sequence is in progress is ignored and does not change its timing.
- R11: `xfer_req_o` is a one-cycle pulse with at most one request outstanding. No request is made while done, and replies arriving while done are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle or done |
| xfer_req_o | output | 1 | One-cycle request to the frame codec |
| xfer_cmd_o | output | 32 | Command word for the codec, valid with `xfer_req_o` |
| xfer_done_i | input | 1 | Codec has finished the outstanding transfer |
| xfer_err_i | input | 1 | Transport error, valid with `xfer_done_i` |
| xfer_rdata_i | input | 32 | 32-bit reply word, valid with `xfer_done_i` |
| done_o | output | 1 | Sequence ended, pass or fail |
| err_o | output | 1 | Sequence ended in failure |
| err_code_o | output | 3 | 0 ok, 1 transport, 2 third reply, 3 fourth reply, 4 fault set |
| warn_o | output | 1 | Power-on reply differed from 0x00000001 |
| fault_o | output | 12 | Fault field captured from the fault-register read |

## Verification
The assertions take for granted that the codec answers each request exactly once with a single `xfer_done_i` cycle, never in the same cycle as the request, and that `start_i` is a one-cycle pulse. The bench's codec model answers each observed request a fixed two cycles later. It drives `start_i` in the middle of a sequence only on cycles with no reply. It sends stray replies only after `done_o`, where the design must ignore them. The bench sweeps the status field and each checked low-byte bit of the third and fourth replies, each fault bit on its own, and a transport error at each of the five transfers. Every expected code, warning and cycle count is computed from the sweep inputs.

// File: rtl/gyro_init_pkg.sv
package gyro_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_RSP,
    ST_END
  } seq_state_e;

  typedef enum logic [2:0] {
    STEP_POR,
    STEP_ARM,
    STEP_CHK3,
    STEP_CHK4,
    STEP_FAULT
  } seq_step_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_XFER   = 3'd1,
    ERR_THIRD  = 3'd2,
    ERR_FOURTH = 3'd3,
    ERR_FAULT  = 3'd4
  } err_code_e;

  localparam int          WORD_W      = 32;
  localparam int          FAULT_W     = 12;
  localparam int          FAULT_LSB   = 5;
  localparam int          ADDR_LSB    = 17;
  localparam logic [7:0]  OP_SENSOR   = 8'h20;
  localparam logic [7:0]  OP_READ     = 8'h80;
  localparam logic [7:0]  FAULT_ADDR  = 8'h0A;
  localparam logic [31:0] POR_REPLY   = 32'h0000_0001;
  localparam logic [1:0]  ST_NORMAL   = 2'b10;

  // sensor-data request; chk sets check and parity bits together
  function automatic logic [WORD_W-1:0] sensor_cmd(input logic chk);
    logic [WORD_W-1:0] w;
    w = {OP_SENSOR, 24'h0};
    if (chk) w[1:0] = 2'b11;
    return w;
  endfunction

  // register read with odd overall parity on bit 0
  function automatic logic [WORD_W-1:0] read_cmd(input logic [7:0] addr);
    logic [WORD_W-1:0] w;
    w = {OP_READ, 24'h0} | ({24'h0, addr} << ADDR_LSB);
    w[0] = ~(^w);
    return w;
  endfunction

endpackage

// File: rtl/gyro_init_timer.sv
module gyro_init_timer #(
  parameter int CLKS_PER_MS = 50000,
  parameter int MS_W        = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] load_ms_i,
  output logic            expired_o
);

  logic            ms_tick;
  logic [MS_W-1:0] ms_q;

  generate
    if (CLKS_PER_MS > 1) begin : g_pre
      localparam int PRE_W = $clog2(CLKS_PER_MS);
      logic [PRE_W-1:0] pre_q;

      // prescaler restarts on load so each delay is exact
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                pre_q <= '0;
        else if (load_i || ms_tick) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      assign ms_tick = (pre_q == PRE_W'(CLKS_PER_MS - 1));
    end else begin : g_nopre
      assign ms_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ms_q <= '0;
    else if (load_i)                  ms_q <= load_ms_i;
    else if (ms_tick && ms_q != '0)   ms_q <= ms_q - 1'b1;
  end

  assign expired_o = (ms_q == '0);

endmodule

// File: rtl/gyro_init_reply_chk.sv
module gyro_init_reply_chk
  import gyro_init_pkg::*;
(
  input  logic [WORD_W-1:0]  rdata_i,
  output logic               por_ok_o,
  output logic               pattern_ok_o,
  output logic [FAULT_W-1:0] fault_o
);

  logic low_ok;
  logic st_ok;

  assign por_ok_o     = (rdata_i == POR_REPLY);
  // bit 0 carries parity and is not part of the pattern
  assign low_ok       = &rdata_i[7:1];
  assign st_ok        = (rdata_i[27:26] == ST_NORMAL);
  assign pattern_ok_o = low_ok && st_ok;
  assign fault_o      = rdata_i[FAULT_LSB +: FAULT_W];

endmodule

// File: rtl/gyro_init_seq.sv
module gyro_init_seq
  import gyro_init_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int POWERUP_MS  = 100,
  parameter int SETTLE_MS   = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               xfer_req_o,
  output logic [WORD_W-1:0]  xfer_cmd_o,
  input  logic               xfer_done_i,
  input  logic               xfer_err_i,
  input  logic [WORD_W-1:0]  xfer_rdata_i,
  output logic               done_o,
  output logic               err_o,
  output logic [2:0]         err_code_o,
  output logic               warn_o,
  output logic [FAULT_W-1:0] fault_o
);

  localparam int MAX_MS = (POWERUP_MS > SETTLE_MS) ? POWERUP_MS : SETTLE_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  seq_state_e         state_q;
  seq_step_e          step_q;
  err_code_e          code_q;
  logic               err_q;
  logic               warn_q;
  logic [FAULT_W-1:0] fault_q;

  logic               accept_start;
  logic               rsp_ok;
  logic               load_t;
  logic [MS_W-1:0]    load_ms;
  logic               expired;
  logic               por_ok;
  logic               pat_ok;
  logic [FAULT_W-1:0] fault_bits;

  assign accept_start = start_i && (state_q == ST_IDLE || state_q == ST_END);
  assign rsp_ok       = (state_q == ST_RSP) && xfer_done_i && !xfer_err_i;
  assign load_t       = accept_start ||
                        (rsp_ok && (step_q == STEP_POR || step_q == STEP_ARM));
  assign load_ms      = accept_start ? MS_W'(POWERUP_MS) : MS_W'(SETTLE_MS);

  gyro_init_timer #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .MS_W        (MS_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_t),
    .load_ms_i (load_ms),
    .expired_o (expired)
  );

  gyro_init_reply_chk u_reply (
    .rdata_i      (xfer_rdata_i),
    .por_ok_o     (por_ok),
    .pattern_ok_o (pat_ok),
    .fault_o      (fault_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_POR;
      code_q  <= ERR_NONE;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
      fault_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_END: begin
          if (start_i) begin
            state_q <= ST_WAIT;
            step_q  <= STEP_POR;
            code_q  <= ERR_NONE;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
            fault_q <= '0;
          end
        end
        ST_WAIT: begin
          if (expired) state_q <= ST_REQ;
        end
        ST_REQ: begin
          state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (xfer_done_i) begin
            if (xfer_err_i) begin
              code_q  <= ERR_XFER;
              err_q   <= 1'b1;
              state_q <= ST_END;
            end else begin
              case (step_q)
                STEP_POR: begin
                  warn_q  <= !por_ok;
                  step_q  <= STEP_ARM;
                  state_q <= ST_WAIT;
                end
                STEP_ARM: begin
                  step_q  <= STEP_CHK3;
                  state_q <= ST_WAIT;
                end
                STEP_CHK3: begin
                  if (pat_ok) begin
                    step_q  <= STEP_CHK4;
                    state_q <= ST_REQ;
                  end else begin
                    code_q  <= ERR_THIRD;
                    err_q   <= 1'b1;
                    state_q <= ST_END;
                  end
                end
                STEP_CHK4: begin
                  if (pat_ok) begin
                    step_q  <= STEP_FAULT;
                    state_q <= ST_REQ;
                  end else begin
                    code_q  <= ERR_FOURTH;
                    err_q   <= 1'b1;
                    state_q <= ST_END;
                  end
                end
                default: begin
                  fault_q <= fault_bits;
                  if (|fault_bits) begin
                    code_q <= ERR_FAULT;
                    err_q  <= 1'b1;
                  end
                  state_q <= ST_END;
                end
              endcase
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (step_q)
      STEP_POR:   xfer_cmd_o = sensor_cmd(1'b1);
      STEP_FAULT: xfer_cmd_o = read_cmd(FAULT_ADDR);
      default:    xfer_cmd_o = sensor_cmd(1'b0);
    endcase
  end

  assign xfer_req_o = (state_q == ST_REQ);
  assign done_o     = (state_q == ST_END);
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign warn_o     = warn_q;
  assign fault_o    = fault_q;

endmodule

// File: rtl/gyro_init_seq_chk.sv
module gyro_init_seq_chk
  import gyro_init_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               xfer_req_o,
  input logic [WORD_W-1:0]  xfer_cmd_o,
  input logic               done_o,
  input logic               err_o,
  input logic [2:0]         err_code_o,
  input logic               warn_o,
  input logic [FAULT_W-1:0] fault_o
);

  a_r11_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);

  a_r11_no_req_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !xfer_req_o);

  a_r11_cmd_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (xfer_cmd_o[31:24] == OP_SENSOR || xfer_cmd_o[31:24] == OP_READ));

  a_r9_err_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r9_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(err_o) && $stable(err_code_o) &&
                          $stable(warn_o) && $stable(fault_o));

  a_r9_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o && !err_o && !warn_o && fault_o == '0);

  a_r9_pass_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> err_code_o == 3'd0);

  a_r7_fault_code_has_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_code_o == 3'd4 |-> fault_o != '0);

endmodule

bind gyro_init_seq gyro_init_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .xfer_req_o (xfer_req_o),
  .xfer_cmd_o (xfer_cmd_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .warn_o     (warn_o),
  .fault_o    (fault_o)
);

// File: tb/gyro_init_seq_test.sv
module gyro_init_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 3;
  localparam int PWR        = 4;
  localparam int SET        = 2;
  localparam int LAT        = 2;
  localparam logic [31:0] CMD_POR   = 32'h2000_0003;
  localparam logic [31:0] CMD_PLAIN = 32'h2000_0000;
  localparam logic [31:0] CMD_FAULT = 32'h8014_0000;
  localparam logic [31:0] GOOD3     = 32'h0800_00FF;
  localparam logic [31:0] GOOD4     = 32'h0800_00FE;
  localparam logic [31:0] GOODF     = 32'h001E_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        xfer_req_o;
  logic [31:0] xfer_cmd_o;
  logic        xfer_done_i = 1'b0;
  logic        xfer_err_i = 1'b0;
  logic [31:0] xfer_rdata_i = '0;
  logic        done_o, err_o, warn_o;
  logic [2:0]  err_code_o;
  logic [11:0] fault_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gyro_init_seq #(
    .CLKS_PER_MS (CPM),
    .POWERUP_MS  (PWR),
    .SETTLE_MS   (SET)
  ) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .xfer_req_o   (xfer_req_o),
    .xfer_cmd_o   (xfer_cmd_o),
    .xfer_done_i  (xfer_done_i),
    .xfer_err_i   (xfer_err_i),
    .xfer_rdata_i (xfer_rdata_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o),
    .warn_o       (warn_o),
    .fault_o      (fault_o)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic bit pat_ok(input logic [31:0] x);
    return (x[7:1] == 7'h7F) && (x[27:26] == 2'b10);
  endfunction

  task automatic run_seq(input logic [31:0] r1, input logic [31:0] r3, input logic [31:0] r4,
                         input logic [31:0] rf, input int xerr, input bit mid_start, input string tag);
    int          txn;
    int          since;
    int          wait_c;
    int          exp_txn;
    int          exp_since;
    bit          exp_warn;
    bit          saw_req;
    logic [2:0]  exp_code;
    logic [11:0] exp_fault;
    logic [31:0] exp_cmd;
    logic [16:0] cap;

    exp_warn = 1'b0;
    exp_code = 3'd0;
    exp_txn  = 5;
    if (xerr == 0) begin exp_code = 3'd1; exp_txn = 1; end
    else begin
      exp_warn = (r1 != 32'h1);
      if (xerr == 1)             begin exp_code = 3'd1; exp_txn = 2; end
      else if (xerr == 2)        begin exp_code = 3'd1; exp_txn = 3; end
      else if (!pat_ok(r3))      begin exp_code = 3'd2; exp_txn = 3; end
      else if (xerr == 3)        begin exp_code = 3'd1; exp_txn = 4; end
      else if (!pat_ok(r4))      begin exp_code = 3'd3; exp_txn = 4; end
      else if (xerr == 4)        begin exp_code = 3'd1; exp_txn = 5; end
      else if (rf[16:5] != 0)    exp_code = 3'd4;
    end
    exp_fault = (exp_code == 3'd0 || exp_code == 3'd4) ? rf[16:5] : 12'h0;

    txn = 0;
    wait_c = -1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    since = 1;
    for (int c = 0; c < 4000; c++) begin
      if (done_o) break;
      if (xfer_req_o) begin
        if (txn >= exp_txn) chk(1'b0, {tag, " R8 request after abort"}, txn, exp_txn);
        exp_cmd   = (txn == 0) ? CMD_POR : ((txn == 4) ? CMD_FAULT : CMD_PLAIN);
        exp_since = (txn == 0) ? PWR * CPM + 2 : ((txn >= 3) ? 1 : SET * CPM + 2);
        chk(xfer_cmd_o == exp_cmd,
            $sformatf("%s R2/R4/R7 command of request %0d", tag, txn), xfer_cmd_o, exp_cmd);
        chk(since == exp_since,
            $sformatf("%s R2/R4/R6 R10 timing of request %0d", tag, txn), since, exp_since);
        wait_c = LAT;
      end
      start_i = (mid_start && c == 3);
      xfer_done_i = 1'b0;
      xfer_err_i = 1'b0;
      if (wait_c == 0) begin
        xfer_done_i = 1'b1;
        xfer_err_i = (txn == xerr);
        case (txn)
          0:       xfer_rdata_i = r1;
          1:       xfer_rdata_i = 32'h5A5A_A5A5;
          2:       xfer_rdata_i = r3;
          3:       xfer_rdata_i = r4;
          default: xfer_rdata_i = rf;
        endcase
        txn++;
        since = 0;
        wait_c = -1;
      end else if (wait_c > 0) begin
        wait_c--;
      end
      @(negedge clk);
      since++;
    end
    start_i = 1'b0;
    xfer_done_i = 1'b0;
    xfer_err_i = 1'b0;

    chk(done_o, {tag, " R9 done raised"}, done_o, 1);
    chk(txn == exp_txn, {tag, " R8 transfer count"}, txn, exp_txn);
    chk(err_code_o == exp_code, {tag, " R5/R6/R7/R8 error code"}, err_code_o, exp_code);
    chk(err_o == (exp_code != 0), {tag, " R9 err flag"}, err_o, exp_code != 0);
    chk(warn_o == exp_warn, {tag, " R3 warning"}, warn_o, exp_warn);
    chk(fault_o == exp_fault, {tag, " R7 fault field"}, fault_o, exp_fault);

    // stray reply while done must change nothing
    cap = {err_o, warn_o, err_code_o, fault_o};
    saw_req = 1'b0;
    xfer_done_i = 1'b1;
    xfer_err_i = 1'b1;
    xfer_rdata_i = '1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    xfer_err_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (xfer_req_o) saw_req = 1'b1;
      @(negedge clk);
    end
    chk(done_o && {err_o, warn_o, err_code_o, fault_o} == cap,
        {tag, " R9 results hold"}, {err_o, warn_o, err_code_o, fault_o}, cap);
    chk(!saw_req, {tag, " R11 no request while done"}, saw_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!done_o && !err_o && !warn_o && !xfer_req_o && err_code_o == 0 && fault_o == 0,
        "R1 reset state", {done_o, err_o, warn_o, xfer_req_o, err_code_o}, 0);

    run_seq(32'h1, GOOD3, GOOD4, GOODF, -1, 1'b0, "R2 nominal");
    run_seq(32'h1, GOOD3, GOOD4, 32'hFFFE_001F, -1, 1'b0, "R7 ignored bits");
    run_seq(32'h1, GOOD3, GOOD4, GOODF, -1, 1'b1, "R10 mid start");
    run_seq(32'h8000_0001, GOOD3, GOOD4, GOODF, -1, 1'b0, "R3 warn hi");
    run_seq(32'h0, GOOD3, GOOD4, GOODF, -1, 1'b0, "R3 warn zero");
    run_seq(32'h3, GOOD3, GOOD4, GOODF, -1, 1'b0, "R3 warn low");

    for (int st = 0; st < 4; st++) begin
      run_seq(32'h1, {4'h0, 2'(st), 18'h0, 8'hFF}, GOOD4, GOODF, -1, 1'b0, "R5 status sweep");
      run_seq(32'h1, GOOD3, {4'h0, 2'(st), 18'h0, 8'hFF}, GOODF, -1, 1'b0, "R6 status sweep");
    end
    for (int b = 0; b < 8; b++) begin
      run_seq(32'h1, 32'h0800_0000 | (32'hFF & ~(32'h1 << b)), GOOD4, GOODF, -1, 1'b0, "R5 low bit sweep");
      run_seq(32'h1, GOOD3, 32'h0800_0000 | (32'hFF & ~(32'h1 << b)), GOODF, -1, 1'b0, "R6 low bit sweep");
    end
    for (int k = 0; k < 12; k++)
      run_seq(32'h1, GOOD3, GOOD4, 32'h1 << (5 + k), -1, 1'b0, "R7 fault bit sweep");
    for (int x = 0; x < 5; x++)
      run_seq(32'h7, GOOD3, GOOD4, GOODF, x, 1'b0, "R8 transport sweep");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule